// File: doc/BRIEF.md
# Watchdog Timer with Tap-Selectable Prescaler

This block watches over software by counting down a programmable interval. A selected tick strobe (peripheral clock enable or slow oscillator enable) feeds a binary prescaler whose terminal point is picked by a 3-bit tap. Each prescaler wrap decrements an 8-bit down counter, which is reloaded from a limit register. When the counter passes zero, a timeout flag rises. Depending on a configuration input, the block then either requests a one-cycle system reset or holds an interrupt request high.

Software reaches the block through a plain write/read register bus with three addresses: control, limit and feed. Restarting the interval takes a two-byte feed: the arm code and then the fire code. Two configuration inputs together lock the watchdog. While locked, it always runs and always counts the oscillator strobe. Everything lives in one clock domain, and both tick sources arrive as single-cycle enables.

Top module: `wdog_top`

## Requirements
- R1: After reset the control register reads 0xE5 (tap 111, run 1, flag 0, clock select 1), the limit reads 0xFF, and the flag, interrupt and reset request outputs are low.
- R2: Address 0 is control: bits [7:5] tap, bit 2 run, bit 1 timeout flag, bit 0 clock select. Bits [4:3] read 0 and ignore writes. Address 1 is the 8-bit limit. Address 2 is the feed address and reads 0.
- R3: After a reload, the flag is set on the selected tick numbered 2^(5+tap)·(limit+1)+1. Tick 1 is the load tick. Tap and limit are sampled on the load tick, so register writes take effect at the next reload.
- R4: After a timeout the counter reloads by itself, and the same period repeats.
- R5: A write of 0xA5 to the feed address, followed by 0x5A to the feed address as the very next write, clears the flag and restarts the period from a fresh load tick. Any other write in between aborts the sequence. A repeated 0xA5 re-arms it.
- R6: Writing control with bit 1 = 0 clears the flag. Writing bit 1 = 1 has no effect. A timeout in the same cycle wins over the clear, and a completed feed wins over a timeout.
- R7: While run reads 0, ticks are ignored and the interval freezes. Counting resumes where it stopped when run is set again.
- R8: With clock select = 1 the oscillator strobe is counted; with 0 the peripheral strobe is counted. The choice applies from the cycle after the write.
- R9: While both configuration inputs are 1, run and clock select read 1 and act as 1, whatever was written.
- R10: With the reset-mode input at 1, each timeout produces a reset request pulse exactly one cycle long, in the cycle the flag rises. The interrupt stays low.
- R11: With the reset-mode input at 0, the interrupt request equals the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_tick_i | input | 1 | Peripheral clock enable strobe |
| osc_tick_i | input | 1 | Watchdog oscillator enable strobe |
| cfg_rst_en_i | input | 1 | 1 selects reset mode, 0 timer mode; also one half of the lock |
| cfg_safe_i | input | 1 | Second lock input |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| wdtof_o | output | 1 | Timeout flag |
| irq_o | output | 1 | Interrupt request (timer mode) |
| rst_req_o | output | 1 | One-cycle reset request (reset mode) |

## Verification
The bench builds the block with its default parameters (base shift 5, 8-bit counter). It drives the peripheral strobe every cycle, which makes even the tap-7 period with limit 0 (4097 ticks) short to run. The small taps and limits exercise load tick, wrap and reload boundaries many times. The oscillator strobe is driven at a sparser rate, so a wrong clock select or a broken lock shows up as a shifted timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int TAP_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LIMIT = 2'd1,
    REG_FEED  = 2'd2,
    REG_SPARE = 2'd3
  } reg_addr_e;

  localparam logic [DATA_W-1:0] FEED_ARM  = 8'hA5;
  localparam logic [DATA_W-1:0] FEED_FIRE = 8'h5A;

  localparam int CTRL_CLK_BIT = 0;
  localparam int CTRL_TOF_BIT = 1;
  localparam int CTRL_RUN_BIT = 2;
  localparam int CTRL_TAP_LSB = 5;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int BASE_SHIFT = 5,
  parameter int TAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             carry_o
);
  localparam int TAP_SPAN = (1 << TAP_W) - 1;
  localparam int PS_W = BASE_SHIFT + TAP_SPAN;

  // Low (BASE_SHIFT + tap) bits set: the prescaler wraps when all are ones.
  function automatic logic [PS_W-1:0] tap_mask(input logic [TAP_W-1:0] tap);
    tap_mask = {PS_W{1'b1}} >> (TAP_SPAN - int'(tap));
  endfunction

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;
  logic            at_end;

  assign mask    = tap_mask(tap_i);
  assign at_end  = (ps_q & mask) == mask;
  assign carry_o = tick_i & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ps_q <= '0;
    else if (clr_i)   ps_q <= '0;
    else if (carry_o) ps_q <= '0;
    else if (tick_i)  ps_q <= ps_q + 1'b1;
  end

  AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ps_q == '0)); // R5
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o       = cnt_q;
  assign underflow_o = step_i & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= limit_i;
    else if (step_i) cnt_q <= cnt_q - 1'b1;
  end

  AST_LOAD_OR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_i, step_i})); // R3
  AST_LOAD_TAKES_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == $past(limit_i))); // R3
endmodule

// File: rtl/wdog_feed.sv
module wdog_feed
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              is_feed_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              fire_o
);
  logic armed_q;

  assign fire_o = wr_i & is_feed_i & (data_i == FEED_FIRE) & armed_q;

  // Every write re-decides the armed state; only the arm code to the feed address keeps it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    armed_q <= 1'b0;
    else if (wr_i) armed_q <= is_feed_i & (data_i == FEED_ARM);
  end

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !armed_q); // R5
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_SHIFT = 5,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_tick_i,
  input  logic              osc_tick_i,
  input  logic              cfg_rst_en_i,
  input  logic              cfg_safe_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wdtof_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  // Stored control fields
  logic [TAP_W-1:0] tap_q, tap_act_q;
  logic             run_q, clksel_q, tof_q;
  logic [CNT_W-1:0] limit_q;
  logic             load_pend_q, rst_req_q;

  // Named internal events
  logic             lock, run_eff, clk_eff, src_tick, tick;
  logic             wr_ctrl, wr_limit, is_feed;
  logic             load_evt, ps_tick, ps_clr, ps_carry;
  logic             feed_fire, underflow;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       unused_wbits;

  assign unused_wbits = bus_wdata_i[4:3];

  assign lock     = cfg_rst_en_i & cfg_safe_i;
  assign run_eff  = run_q | lock;
  assign clk_eff  = clksel_q | lock;
  assign src_tick = clk_eff ? osc_tick_i : pclk_tick_i;
  assign tick     = run_eff & src_tick;

  assign wr_ctrl  = bus_wr_i & (reg_addr_e'(bus_addr_i) == REG_CTRL);
  assign wr_limit = bus_wr_i & (reg_addr_e'(bus_addr_i) == REG_LIMIT);
  assign is_feed  = reg_addr_e'(bus_addr_i) == REG_FEED;

  // The first tick after a reload only loads; later ticks drive the prescaler.
  assign load_evt = tick & load_pend_q;
  assign ps_tick  = tick & ~load_pend_q;
  assign ps_clr   = load_evt | feed_fire;

  wdog_feed u_feed (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bus_wr_i),
    .is_feed_i(is_feed),
    .data_i   (bus_wdata_i),
    .fire_o   (feed_fire)
  );

  wdog_prescaler #(
    .BASE_SHIFT(BASE_SHIFT),
    .TAP_W     (TAP_W)
  ) u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ps_clr),
    .tick_i (ps_tick),
    .tap_i  (tap_act_q),
    .carry_o(ps_carry)
  );

  wdog_downcnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_evt),
    .limit_i    (limit_q),
    .step_i     (ps_carry),
    .cnt_o      (cnt),
    .underflow_o(underflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q       <= '1;
      tap_act_q   <= '1;
      run_q       <= 1'b1;
      clksel_q    <= 1'b1;
      tof_q       <= 1'b0;
      limit_q     <= '1;
      load_pend_q <= 1'b1;
      rst_req_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        tap_q    <= bus_wdata_i[CTRL_TAP_LSB +: TAP_W];
        run_q    <= bus_wdata_i[CTRL_RUN_BIT];
        clksel_q <= bus_wdata_i[CTRL_CLK_BIT];
      end
      if (wr_limit) limit_q <= bus_wdata_i[CNT_W-1:0];

      if (load_evt) tap_act_q <= tap_q;

      if (feed_fire | underflow) load_pend_q <= 1'b1;
      else if (load_evt)         load_pend_q <= 1'b0;

      if (feed_fire)                                  tof_q <= 1'b0;
      else if (underflow)                             tof_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata_i[CTRL_TOF_BIT]) tof_q <= 1'b0;

      rst_req_q <= underflow & ~feed_fire & cfg_rst_en_i;
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr_i))
      REG_CTRL:  bus_rdata_o = {tap_q, 2'b00, run_eff, tof_q, clk_eff};
      REG_LIMIT: bus_rdata_o = DATA_W'(limit_q);
      default:   bus_rdata_o = '0;
    endcase
  end

  assign wdtof_o   = tof_q;
  assign irq_o     = tof_q & ~cfg_rst_en_i;
  assign rst_req_o = rst_req_q;

  AST_FEED_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    feed_fire |=> !wdtof_o); // R5
  AST_UNDERFLOW_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !feed_fire) |=> wdtof_o); // R3
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_eff |=> $stable(cnt)); // R7
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o); // R10
  AST_LOCK_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && reg_addr_e'(bus_addr_i) == REG_CTRL) |-> (bus_rdata_o[CTRL_RUN_BIT] && bus_rdata_o[CTRL_CLK_BIT])); // R9
endmodule

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk_tick = 1'b0, osc_tick = 1'b0;
  logic       cfg_rst_en = 1'b0, cfg_safe = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wdtof, irq, rst_req;

  always #4 clk = ~clk; // 125 MHz

  wdog_top u_wdog_top (
    .clk(clk), .rst_n(rst_n), .pclk_tick_i(pclk_tick), .osc_tick_i(osc_tick),
    .cfg_rst_en_i(cfg_rst_en), .cfg_safe_i(cfg_safe), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .wdtof_o(wdtof), .irq_o(irq), .rst_req_o(rst_req)
  );

  int    vectors = 0, miscompares = 0, cycles = 0;
  int    osc_div = 3, cyc = 0;
  string phase = "R1";
  bit    done = 0;

  // Behavioural reference: ticks remaining in the interval, no prescaler.
  int   m_tap, m_wdl, m_left;
  bit   m_run, m_clk, m_tof, m_armed, m_pend, m_rstreq;

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_tap = 7; m_wdl = 255; m_left = 0;
    m_run = 1; m_clk = 1; m_tof = 0; m_armed = 0; m_pend = 1; m_rstreq = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    bit lock, tk, feed, uf;
    int exp_rd;
    if (!rst_n) model_reset();
    else begin
      lock = cfg_rst_en && cfg_safe;
      tk   = (m_run || lock) && ((m_clk || lock) ? osc_tick : pclk_tick);
      feed = bus_wr && bus_addr == 2'd2 && bus_wdata == 8'h5A && m_armed;
      uf   = 0;
      if (tk) begin
        if (m_pend) begin
          m_pend = 0;
          m_left = (1 << (5 + m_tap)) * (m_wdl + 1);
        end else begin
          m_left--;
          if (m_left == 0) begin uf = 1; m_pend = 1; end
        end
      end
      if (feed) m_pend = 1;
      m_rstreq = uf && !feed && cfg_rst_en;
      if (feed) m_tof = 0;
      else if (uf) m_tof = 1;
      else if (bus_wr && bus_addr == 2'd0 && !bus_wdata[1]) m_tof = 0;
      if (bus_wr && bus_addr == 2'd0) begin
        m_tap = bus_wdata[7:5]; m_run = bus_wdata[2]; m_clk = bus_wdata[0];
      end
      if (bus_wr && bus_addr == 2'd1) m_wdl = bus_wdata;
      if (bus_wr) m_armed = (bus_addr == 2'd2 && bus_wdata == 8'hA5);
    end
    #1;
    if (rst_n && !done) begin
      lock = cfg_rst_en && cfg_safe;
      case (bus_addr)
        2'd0: exp_rd = {m_tap[2:0], 2'b00, m_run || lock, m_tof, m_clk || lock};
        2'd1: exp_rd = m_wdl;
        default: exp_rd = 0;
      endcase
      check(phase, "rdata", bus_rdata, exp_rd);
      check(phase, "wdtof", wdtof, m_tof);
      check(phase, "irq R11", irq, m_tof && !cfg_rst_en);
      check(phase, "rst_req R10", rst_req, m_rstreq);
    end
  end

  // Tick strobes: peripheral every cycle, oscillator every osc_div cycles.
  initial forever begin
    @(negedge clk);
    cyc++;
    pclk_tick = 1'b1;
    osc_tick  = (cyc % osc_div) == 0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      miscompares++; vectors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic rd(input logic [1:0] a); @(negedge clk); bus_addr = a; endtask

  // Stop, program tap and limit, feed, then start on the peripheral strobe.
  task automatic restart(input int tap, input int lim);
    wr(2'd0, 8'(tap << 5));
    wr(2'd1, 8'(lim));
    wr(2'd2, 8'hA5);
    wr(2'd2, 8'h5A);
    wr(2'd0, 8'((tap << 5) | 4));
  endtask

  initial begin
    int n, pulses;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    // R1 reset values
    check("R1", "ctrl", bus_rdata, 8'hE5);
    rd(2'd1); idle(1); check("R1", "limit", bus_rdata, 8'hFF);
    check("R1", "flags", {wdtof, irq, rst_req}, 0);
    rd(2'd2); idle(1); check("R2", "feed read", bus_rdata, 0);
    // R2 reserved bits and fields
    phase = "R2";
    wr(2'd0, 8'h1A); bus_addr = 2'd0; idle(1);
    check("R2", "ctrl reserved", bus_rdata, 8'h00);
    // R3 timeout length, tap 0 limit 0
    phase = "R3";
    restart(0, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!wdtof && n < 5000);
    check("R3", "ticks to flag", n, 33);
    // R4 auto reload and R11 interrupt follows flag
    phase = "R4"; idle(100);
    phase = "R6"; wr(2'd0, 8'h06); idle(5); wr(2'd0, 8'h04); idle(40);
    // R3 larger taps, limit sampled at load
    phase = "R3"; restart(1, 3); wr(2'd1, 8'h01); idle(600);
    restart(7, 0); idle(4200);
    restart(2, 2); idle(500);
    // R5 feeds, abort and re-arm
    phase = "R5";
    restart(1, 3); idle(150); wr(2'd2, 8'hA5); wr(2'd2, 8'h5A); idle(200);
    wr(2'd2, 8'hA5); wr(2'd1, 8'h03); wr(2'd2, 8'h5A); idle(150);
    wr(2'd2, 8'hA5); wr(2'd2, 8'hA5); wr(2'd2, 8'h5A); idle(300);
    wr(2'd2, 8'hA5); wr(2'd2, 8'h11); wr(2'd2, 8'h5A); idle(100);
    // R7 run control freezes the interval
    phase = "R7";
    restart(0, 1); idle(20); wr(2'd0, 8'h00); idle(200);
    check("R7", "frozen flag", wdtof, 0);
    wr(2'd0, 8'h04); idle(80);
    // R8 oscillator strobe select
    phase = "R8"; osc_div = 3;
    restart(0, 0); wr(2'd0, 8'h05); idle(250); wr(2'd0, 8'h04); idle(100);
    // R9 lock forces run and oscillator
    phase = "R9";
    cfg_rst_en = 1'b1; cfg_safe = 1'b1;
    wr(2'd0, 8'h00); bus_addr = 2'd0; idle(1);
    check("R9", "locked ctrl", bus_rdata[2:0] & 3'b101, 3'b101);
    idle(300);
    cfg_safe = 1'b0; idle(5);
    // R10 reset mode pulse
    phase = "R10";
    restart(0, 0);
    pulses = 0;
    repeat (40) begin @(negedge clk); if (rst_req) pulses++; end
    check("R10", "pulses", pulses, 1);
    check("R10", "irq low", irq, 0);
    idle(100);
    // R11 timer mode interrupt
    phase = "R11"; cfg_rst_en = 1'b0; idle(100);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule